// File: doc/BRIEF.md
# Four-Strike Watchdog Timer

This block is a watchdog that sits on a simple single-cycle register bus. It has its own companion down-counter, driven by a 1 MHz tick enable, that produces periodic wrap events. Each wrap takes one step off the watchdog's programmed period count. When that count runs out, it reloads and an expiry counter moves up. The first three expiries can raise an interrupt. The fourth raises a system reset request. The total time to reset is therefore four programmed periods.

Software writes the configuration, starts the counter, and pings it by writing the start command again. Stopping the watchdog is protected: a stop command is honoured only when the write just before it was the unlock key. The status register shows the remaining count and the expiry count, so software can estimate the time left. Writing zero to the timer register stops the ticks, and the watchdog then holds its state. There is no data stream here. Every pin is plain control or status, and bus writes take effect at the clock edge where `bus_wr` is high.

Top module: `wdt_multi_expiry`

## Requirements
- R1: After reset, every register reads zero, `irq` and `rst_req` are low, and the watchdog is stopped.
- R2: The timer register at offset 0x10 holds enable (bit 31), auto-reload (bit 30) and a reload value (bits 29:0). While enabled it wraps once every reload+1 ticks. Without auto-reload it clears its enable after the first wrap.
- R3: The configuration register at offset 0x0 holds the period in bits 11:4, interrupt enable in bit 12 and reset enable in bit 15, and reads back as stored. A period of 0 is stored as 1.
- R4: Writing bit 0 of the command register (offset 0x8) starts the watchdog, or restarts it if it is already running. This loads the count from the period and clears the expiry count and `irq`.
- R5: Each timer wrap while running decrements the count. When the count would reach zero it reloads from the period and the expiry count increments. Status at offset 0x4 shows the count in bits 11:4 and the expiry count in bits 13:12.
- R6: Expiries one to three set `irq` when bit 12 is set. `irq` stays high until a start or a stop command.
- R7: The fourth expiry sets `rst_req` when bit 15 is set. `rst_req` stays high until bus reset, and the expiry count saturates at 3.
- R8: Command bit 1 stops the watchdog and freezes its count only if the previous bus write put 0xC45A into offset 0xC. Without that, bit 1 is ignored and counting continues.
- R9: The unlock is consumed by the next bus write of any kind.
- R10: Writing 0 to the timer register stops wraps, and the watchdog count and expiry count hold their values.
- R11: `bus_rdata` shows the register at `bus_addr` combinationally. The unlock offset and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous bus reset |
| tick_en | input | 1 | 1 MHz tick enable, one clock wide |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Early-expiry interrupt, level |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The bench targets the boundary between the third and fourth expiry. A design that counted one expiry too few or too many would raise `rst_req` at the wrong tick, or would let the expiry field wrap to zero. It checks the stop protocol three ways: with the key, without the key, and with another write in between. A design that kept the unlock alive too long would stop when it should keep running. It also covers the period-of-zero clamp, a one-shot timer that must not keep counting, a multi-tick reload, and `rst_req` surviving a ping. A design that did not freeze on a disabled timer, or that cleared the reset request on a restart, would be caught there.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int PERIOD_W = 8;
  localparam int EXP_W    = 2;
  localparam int RELOAD_W = 30;

  localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_UNLOCK = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_TIMER  = 8'h10;

  localparam logic [15:0] UNLOCK_KEY = 16'hC45A;

  typedef struct packed {
    logic                rst_en;
    logic                irq_en;
    logic [PERIOD_W-1:0] period;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_tick_timer.sv
module wdt_tick_timer #(
  parameter int RW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load,
  input  logic          load_en,
  input  logic          load_auto,
  input  logic [RW-1:0] load_val,
  output logic          run,
  output logic          auto,
  output logic [RW-1:0] reload,
  output logic          wrap
);
  logic [RW-1:0] cnt_q;

  assign wrap = run && tick_en && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      auto   <= 1'b0;
      reload <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      run    <= load_en;
      auto   <= load_auto;
      reload <= load_val;
      cnt_q  <= load_val;
    end else if (run && tick_en) begin
      if (cnt_q == '0) begin
        cnt_q <= reload;
        if (!auto) run <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_unlock_gate.sv
module wdt_unlock_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic any_wr,
  input  logic key_hit,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (any_wr) armed <= key_hit;
  end
endmodule

// File: rtl/wdt_expiry_core.sv
module wdt_expiry_core
  import wdt_pkg::*;
#(
  parameter int PW = PERIOD_W,
  parameter int EW = EXP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          wrap,
  input  logic [PW-1:0] period,
  input  logic          irq_en,
  input  logic          rst_en,
  output logic          running,
  output logic [PW-1:0] count,
  output logic [EW-1:0] exp_cnt,
  output logic          irq,
  output logic          rst_req
);
  localparam logic [EW-1:0] EXP_MAX = '1;
  logic [PW-1:0] period_eff;

  assign period_eff = (period == '0) ? PW'(1) : period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
      exp_cnt <= '0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else if (stop) begin
      running <= 1'b0;
      irq     <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      count   <= period_eff;
      exp_cnt <= '0;
      irq     <= 1'b0;
    end else if (running && wrap) begin
      if (count <= PW'(1)) begin
        count <= period_eff;
        if (exp_cnt == EXP_MAX) begin
          if (rst_en) rst_req <= 1'b1;
        end else begin
          exp_cnt <= exp_cnt + 1'b1;
          if (irq_en) irq <= 1'b1;
        end
      end else begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_multi_expiry.sv
module wdt_multi_expiry
  import wdt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PERIOD_W,
  parameter int EW = EXP_W,
  parameter int RW = RELOAD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          rst_req
);
  localparam int LOW_W = DW - 2;

  wdt_cfg_t      cfg_q;
  logic          wr_cfg, wr_cmd, wr_tmr, key_hit, armed;
  logic          start_cmd, stop_cmd;
  logic          tmr_run, tmr_auto, wrap;
  logic [RW-1:0] tmr_reload;
  logic          running;
  logic [PW-1:0] count;
  logic [EW-1:0] exp_cnt;
  logic [PW-1:0] wr_period;

  assign wr_cfg    = bus_wr && (bus_addr == OFF_CFG);
  assign wr_cmd    = bus_wr && (bus_addr == OFF_CMD);
  assign wr_tmr    = bus_wr && (bus_addr == OFF_TIMER);
  assign key_hit   = bus_wr && (bus_addr == OFF_UNLOCK) && (bus_wdata[15:0] == UNLOCK_KEY);
  assign stop_cmd  = wr_cmd && bus_wdata[1] && armed;
  assign start_cmd = wr_cmd && bus_wdata[0];
  assign wr_period = bus_wdata[4 +: PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      cfg_q.period <= (wr_period == '0) ? PW'(1) : wr_period;
      cfg_q.irq_en <= bus_wdata[12];
      cfg_q.rst_en <= bus_wdata[15];
    end
  end

  wdt_unlock_gate u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .any_wr (bus_wr),
    .key_hit(key_hit),
    .armed  (armed)
  );

  wdt_tick_timer #(.RW(RW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load     (wr_tmr),
    .load_en  (bus_wdata[DW-1]),
    .load_auto(bus_wdata[DW-2]),
    .load_val (bus_wdata[RW-1:0]),
    .run      (tmr_run),
    .auto     (tmr_auto),
    .reload   (tmr_reload),
    .wrap     (wrap)
  );

  wdt_expiry_core #(.PW(PW), .EW(EW)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_cmd),
    .stop   (stop_cmd),
    .wrap   (wrap),
    .period (cfg_q.period),
    .irq_en (cfg_q.irq_en),
    .rst_en (cfg_q.rst_en),
    .running(running),
    .count  (count),
    .exp_cnt(exp_cnt),
    .irq    (irq),
    .rst_req(rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CFG: begin
        bus_rdata[4 +: PW] = cfg_q.period;
        bus_rdata[12]      = cfg_q.irq_en;
        bus_rdata[15]      = cfg_q.rst_en;
      end
      OFF_STAT: begin
        bus_rdata[4 +: PW]  = count;
        bus_rdata[12 +: EW] = exp_cnt;
      end
      OFF_TIMER: bus_rdata = {tmr_run, tmr_auto, LOW_W'(tmr_reload)};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_multi_expiry_chk.sv
module wdt_multi_expiry_chk #(
  parameter int PW = 8,
  parameter int EW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          any_wr,
  input logic          wr_cmd,
  input logic          armed,
  input logic          running,
  input logic          tmr_run,
  input logic [PW-1:0] count,
  input logic [EW-1:0] exp_cnt,
  input logic          irq,
  input logic          irq_en,
  input logic          rst_req
);
  // R7
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  // R7
  rst_after_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(exp_cnt) == '1));

  // R5
  count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (count != '0));

  // R8
  locked_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !armed && running) |=> running);

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_run && !any_wr) |=> ($stable(count) && $stable(exp_cnt)));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en));
endmodule

bind wdt_multi_expiry wdt_multi_expiry_chk #(.PW(PW), .EW(EW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .any_wr (bus_wr),
  .wr_cmd (wr_cmd),
  .armed  (armed),
  .running(running),
  .tmr_run(tmr_run),
  .count  (count),
  .exp_cnt(exp_cnt),
  .irq    (irq),
  .irq_en (cfg_q.irq_en),
  .rst_req(rst_req)
);

// File: tb/wdt_multi_expiry_bench.sv
module wdt_multi_expiry_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  wdt_multi_expiry u_wdt_multi_expiry (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  // op: 0 write, 1 read-compare, 2 ticks (data = number), 3 pins {rst_req, irq}
  localparam int NV = 22;
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 8'h00, 32'h0000_9030, 32'h0},      // R3 period 3, irq and reset enabled
    {2'd1, 8'h00, 32'h0,         32'h0000_9030}, // R3 readback
    {2'd0, 8'h10, 32'hC000_0000, 32'h0},      // R2 auto-reload, wrap each tick
    {2'd0, 8'h08, 32'h1,         32'h0},      // R4 start
    {2'd1, 8'h04, 32'h0,         32'h0000_0030}, // R4 count loaded
    {2'd2, 8'h00, 32'd1,         32'h0},
    {2'd1, 8'h04, 32'h0,         32'h0000_0020}, // R5 decrement
    {2'd2, 8'h00, 32'd2,         32'h0},
    {2'd1, 8'h04, 32'h0,         32'h0000_1030}, // R5 first expiry
    {2'd3, 8'h00, 32'h0,         32'h1},      // R6 irq set
    {2'd0, 8'h08, 32'h1,         32'h0},      // R4 ping
    {2'd1, 8'h04, 32'h0,         32'h0000_0030}, // R4 cleared
    {2'd3, 8'h00, 32'h0,         32'h0},      // R4 irq cleared
    {2'd2, 8'h00, 32'd9,         32'h0},
    {2'd1, 8'h04, 32'h0,         32'h0000_3030}, // R5 third expiry
    {2'd3, 8'h00, 32'h0,         32'h1},      // R6 no reset yet
    {2'd2, 8'h00, 32'd3,         32'h0},
    {2'd1, 8'h04, 32'h0,         32'h0000_3030}, // R7 saturate at 3
    {2'd3, 8'h00, 32'h0,         32'h3},      // R7 reset request
    {2'd0, 8'h08, 32'h2,         32'h0},      // R8 stop without key
    {2'd2, 8'h00, 32'd1,         32'h0},
    {2'd1, 8'h04, 32'h0,         32'h0000_3020}  // R8 still counting
  };

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s: addr %h got %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic pins(input logic [1:0] e, input string tag);
    @(negedge clk);
    #1;
    checks++;
    if ({rst_req, irq} !== e) begin
      errors++;
      $display("FAIL %s: pins got %b expected %b", tag, {rst_req, irq}, e);
    end
  endtask

  initial begin
    do_reset();
    // R1 reset state
    rd(8'h00, 32'h0, "R1 cfg");
    rd(8'h04, 32'h0, "R1 status");
    rd(8'h10, 32'h0, "R1 timer");
    pins(2'b00, "R1 pins");
    rd(8'h14, 32'h0, "R11 unmapped");

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][73:72])
        2'd0: wr(VEC[v][71:64], VEC[v][63:32]);
        2'd1: rd(VEC[v][71:64], VEC[v][31:0], $sformatf("vector %0d", v));
        2'd2: ticks(int'(VEC[v][63:32]));
        default: pins(VEC[v][1:0], $sformatf("vector %0d", v));
      endcase
    end

    // R8 unlocked stop freezes
    do_reset();
    wr(8'h00, 32'h0000_0030);
    wr(8'h10, 32'hC000_0000);
    wr(8'h08, 32'h1);
    ticks(1);
    wr(8'h0C, 32'h0000_C45A);
    rd(8'h0C, 32'h0, "R11 unlock reads zero");
    wr(8'h08, 32'h2);
    ticks(5);
    rd(8'h04, 32'h0000_0020, "R8 stopped count held");
    pins(2'b00, "R6 irq disabled");

    // R9 unlock consumed by an intervening write
    wr(8'h08, 32'h1);
    wr(8'h0C, 32'h0000_C45A);
    wr(8'h00, 32'h0000_0030);
    wr(8'h08, 32'h2);
    ticks(1);
    rd(8'h04, 32'h0000_0020, "R9 still running");

    // R10 timer off freezes the watchdog
    wr(8'h10, 32'h0);
    ticks(4);
    rd(8'h04, 32'h0000_0020, "R10 frozen");
    rd(8'h10, 32'h0, "R10 timer readback");

    // R3 period zero clamps to one; R7 no reset when disabled
    do_reset();
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0000_0010, "R3 clamp");
    wr(8'h10, 32'hC000_0000);
    wr(8'h08, 32'h1);
    ticks(1);
    rd(8'h04, 32'h0000_1010, "R5 period one expiry");
    ticks(3);
    rd(8'h04, 32'h0000_3010, "R7 saturated");
    pins(2'b00, "R7 reset disabled");

    // R2 reload of 2 means three ticks per wrap
    do_reset();
    wr(8'h00, 32'h0000_0020);
    wr(8'h10, 32'hC000_0002);
    rd(8'h10, 32'hC000_0002, "R2 timer readback");
    wr(8'h08, 32'h1);
    ticks(2);
    rd(8'h04, 32'h0000_0020, "R2 no wrap yet");
    ticks(1);
    rd(8'h04, 32'h0000_0010, "R2 wrap on third tick");

    // R2 one-shot timer wraps once
    do_reset();
    wr(8'h00, 32'h0000_0030);
    wr(8'h10, 32'h8000_0000);
    wr(8'h08, 32'h1);
    ticks(3);
    rd(8'h04, 32'h0000_0020, "R2 one-shot");
    rd(8'h10, 32'h0, "R2 one-shot disabled");

    // R7 reset request survives a ping
    do_reset();
    wr(8'h00, 32'h0000_8010);
    wr(8'h10, 32'hC000_0000);
    wr(8'h08, 32'h1);
    ticks(4);
    pins(2'b10, "R7 fourth expiry");
    wr(8'h08, 32'h1);
    pins(2'b10, "R7 sticky after ping");
    rd(8'h04, 32'h0000_0010, "R4 ping reload");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule